// File: doc/BRIEF.md
# State-Feedback Current Loop with Fixed-Frequency PWM

This block closes the inner current loop of a switching DC-DC converter. On each sample strobe it takes the current reference produced by an outer voltage loop, the measured inductor current and the measured output voltage. It forms a duty command from a weighted sum of two state terms: the current error, scaled by a gain near unity, and the output voltage, scaled by a gain about a thousand times larger. The command is floored to the PWM tick resolution and limited to a safe window of the switching period.

The command drives a fixed-frequency PWM generator for a single power switch. A gate value of 1 closes the switch and 0 opens it. The generator loads a new duty only when its period counter wraps, so every period runs whole at one duty value. The active duty is also driven out as a port.

Top module: `sfb_current_loop`

## Requirements
- R1: While rst_ni is low, and after it rises until a strobe has been captured and a period wrap has passed, gate_o is 0 and duty_o is 0.
- R2: On a clock edge with sample_i high, the command becomes floor((K1_Q*(iref_i - il_i) - K2_Q*vo_i) / 2^FRAC_W). This is computed with signed inputs and no intermediate overflow. The defaults are K1_Q=284, K2_Q=256000 and FRAC_W=8.
- R3: A command below DUTY_MIN (5% of PERIOD, 50 ticks by default) is raised to DUTY_MIN.
- R4: A command above DUTY_MAX (90% of PERIOD, 900 ticks by default) is lowered to DUTY_MAX. This holds for full-scale inputs, with no wrap-around.
- R5: duty_o takes the latest command only on the edge where the period counter wraps from PERIOD-1 to 0. A strobe in the middle of a period leaves duty_o unchanged until the next wrap.
- R6: Each period is PERIOD clock cycles long (1000 by default) and starts with the wrap. gate_o is 1 for exactly duty_o cycles at the start of the period and 0 for the rest.
- R7: Input changes made while sample_i is low have no effect on the command.
- R8: When several strobes fall in one period, the last one sets the duty of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Strobe that captures a new sample set |
| iref_i | input | DATA_W | Signed current reference from the outer loop |
| il_i | input | DATA_W | Signed inductor current sample |
| vo_i | input | DATA_W | Signed output voltage sample |
| gate_o | output | 1 | Switch drive, 1 = switch closed |
| duty_o | output | CNT_W | Duty in clock ticks, active in this period |

## Verification
The assertions take for granted that rst_ni is released away from the clock edge. They also assume sample_i is a single-cycle strobe with the three samples stable in that cycle, and that the gains and input widths keep every product within 64 signed bits. The stimulus drives all inputs on the falling edge and pulses the strobe for one cycle. It places strobes just after a wrap or in the middle of a period, never on the wrap edge itself, so the load timing is unambiguous. Full-scale sample values are used only to push the clamps, and they stay inside the 64-bit product range.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef logic signed [63:0] acc_t;

  function automatic acc_t clamp(acc_t v, acc_t lo, acc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/sfb_law.sv
module sfb_law import sfb_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int K1_Q     = 284,
  parameter int K2_Q     = 256000,
  parameter int FRAC_W   = 8,
  parameter int DUTY_MIN = 50,
  parameter int DUTY_MAX = 900
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic signed [DATA_W-1:0] iref_i,
  input  logic signed [DATA_W-1:0] il_i,
  input  logic signed [DATA_W-1:0] vo_i,
  output logic        [CNT_W-1:0]  cmd_o
);
  localparam acc_t K1_A = acc_t'(K1_Q);
  localparam acc_t K2_A = acc_t'(K2_Q);
  localparam acc_t LO_A = acc_t'(DUTY_MIN);
  localparam acc_t HI_A = acc_t'(DUTY_MAX);

  acc_t err_w, acc_w, shf_w, lim_w;
  logic [CNT_W-1:0] cmd_q;

  always_comb begin
    err_w = acc_t'(iref_i) - acc_t'(il_i);
    acc_w = (err_w * K1_A) - (acc_t'(vo_i) * K2_A);
    shf_w = acc_w >>> FRAC_W;  // floor toward minus infinity
    lim_w = clamp(shf_w, LO_A, HI_A);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_q <= '0;
    else if (sample_i) cmd_q <= CNT_W'(lim_w);
  end

  assign cmd_o = cmd_q;

  p_cmd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(cmd_q));
endmodule

// File: rtl/sfb_pwm.sv
module sfb_pwm #(
  parameter int PERIOD   = 1000,
  parameter int CNT_W    = 10,
  parameter int DUTY_MIN = 50,
  parameter int DUTY_MAX = 900
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cmd_i,
  output logic [CNT_W-1:0] duty_o,
  output logic             gate_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, duty_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else if (wrap) begin
      cnt_q  <= '0;
      duty_q <= cmd_i;  // shadow load only at period boundary
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign gate_o = (cnt_q < duty_q);
  assign duty_o = duty_q;

  p_duty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(duty_q));
  p_duty_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q != '0) |-> (duty_q >= CNT_W'(DUTY_MIN) && duty_q <= CNT_W'(DUTY_MAX)));
  p_gate_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && duty_q != '0) |-> gate_o);
  p_gate_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> (cnt_q == duty_q));
  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/sfb_current_loop.sv
module sfb_current_loop #(
  parameter int DATA_W  = 16,
  parameter int PERIOD  = 1000,
  parameter int MIN_PCT = 5,
  parameter int MAX_PCT = 90,
  parameter int K1_Q    = 284,
  parameter int K2_Q    = 256000,
  parameter int FRAC_W  = 8,
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic signed [DATA_W-1:0] iref_i,
  input  logic signed [DATA_W-1:0] il_i,
  input  logic signed [DATA_W-1:0] vo_i,
  output logic                     gate_o,
  output logic        [CNT_W-1:0]  duty_o
);
  localparam int DUTY_MIN = PERIOD * MIN_PCT / 100;
  localparam int DUTY_MAX = PERIOD * MAX_PCT / 100;

  logic [CNT_W-1:0] cmd;

  sfb_law #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .K1_Q(K1_Q), .K2_Q(K2_Q),
    .FRAC_W(FRAC_W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
  ) u_law (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
    .iref_i(iref_i), .il_i(il_i), .vo_i(vo_i), .cmd_o(cmd)
  );

  sfb_pwm #(
    .PERIOD(PERIOD), .CNT_W(CNT_W), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
  ) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd),
    .duty_o(duty_o), .gate_o(gate_o)
  );
endmodule

// File: tb/sfb_current_loop_tb.sv
module sfb_current_loop_tb;
  localparam int  DATA_W = 16;
  localparam int  PERIOD = 1000;
  localparam int  CNT_W  = $clog2(PERIOD);
  localparam longint K1  = 284;
  localparam longint K2  = 256000;
  localparam int  FRAC   = 8;
  localparam longint DMIN = 50;
  localparam longint DMAX = 900;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_i = 1'b0;
  logic signed [DATA_W-1:0] iref_i = '0, il_i = '0, vo_i = '0;
  logic gate_o;
  logic [CNT_W-1:0] duty_o;

  int checks = 0;
  int errors = 0;
  longint ncyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_ni) ncyc <= 0;
    else         ncyc <= ncyc + 1;
  end

  sfb_current_loop u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i),
    .iref_i(iref_i), .il_i(il_i), .vo_i(vo_i),
    .gate_o(gate_o), .duty_o(duty_o)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(longint r, longint l, longint v);
    longint s;
    s = (K1 * (r - l) - K2 * v) >>> FRAC;
    if (s < DMIN) s = DMIN;
    if (s > DMAX) s = DMAX;
    return s;
  endfunction

  task automatic do_sample(longint r, longint l, longint v);
    @(negedge clk);
    iref_i = DATA_W'(r); il_i = DATA_W'(l); vo_i = DATA_W'(v);
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
  endtask

  task automatic wait_start;
    @(negedge clk);
    while (ncyc % PERIOD != 0) @(negedge clk);
  endtask

  // called at period start; ends at the next period start
  task automatic measure(output int highs);
    highs = 0;
    for (int i = 0; i < PERIOD; i++) begin
      highs += int'(gate_o);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int h;
    #35;
    chk("R1 gate in reset", gate_o, 0);
    chk("R1 duty in reset", duty_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    wait_start;
    measure(h);
    chk("R1 gate idle without strobe", h, 0);
    chk("R1 duty idle without strobe", duty_o, 0);
  endtask

  task automatic t_law(longint r, longint l, longint v, string req);
    int h;
    wait_start;
    do_sample(r, l, v);
    wait_start;
    chk(req, duty_o, model(r, l, v));
    measure(h);
    chk("R6 gate high cycles", h, model(r, l, v));
  endtask

  task automatic t_hold;
    longint old;
    wait_start;
    do_sample(500, 100, 0);
    wait_start;
    old = duty_o;
    repeat (300) @(negedge clk);
    do_sample(1000, 0, 1);
    repeat (5) @(negedge clk);
    chk("R5 duty held mid period", duty_o, old);
    wait_start;
    chk("R5 duty after wrap", duty_o, model(1000, 0, 1));
  endtask

  task automatic t_strobe;
    longint old;
    wait_start;
    old = duty_o;
    @(negedge clk);
    iref_i = 16'sd2000; il_i = -16'sd2000; vo_i = -16'sd3;
    repeat (20) @(negedge clk);
    wait_start;
    chk("R7 inputs without strobe ignored", duty_o, old);
  endtask

  task automatic t_last;
    wait_start;
    do_sample(300, 0, 0);
    repeat (10) @(negedge clk);
    do_sample(500, 100, 0);
    wait_start;
    chk("R8 last strobe wins", duty_o, model(500, 100, 0));
  endtask

  initial begin
    t_reset;
    t_law(500, 100, 0, "R2 pattern a");
    t_law(1000, 0, 1, "R2 pattern b");
    t_law(300, 0, 0, "R2 pattern c");
    t_law(-200, 300, 0, "R3 low clamp");
    t_law(-32768, 32767, 32767, "R3 low clamp full scale");
    t_law(0, 0, -1, "R4 high clamp");
    t_law(32767, -32768, -32768, "R4 high clamp full scale");
    t_hold;
    t_strobe;
    t_last;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule